// File: doc/BRIEF.md
# PWM Synchronization Trigger Controller

This block chooses when buffered period and channel compare values are moved into the active registers of a PWM timer. Four sources can request this move. Three are external hardware trigger lines, each gated by its own arm bit. The fourth is a software request bit. The arm bits and the software bit sit in one control register that is written over a simple write-only bus. The same bits are also driven out continuously, so the owner of the block can see which triggers are still armed.

An arm bit disarms itself once its trigger has been consumed. The software bit clears itself once the load it asked for has been made. In both cases a register write in the same cycle takes priority over the self-clear.

A mode input decides when the load happens. With the mode low, a request waits for the counter-boundary indication, and all requests waiting at that boundary are served by one load. With the mode high, the load is issued on the next cycle without waiting, together with a counter-reinitialization pulse.

Top module: `psync_trigger_ctrl`

## Requirements
- R1: After reset, all trigger bits on `trig_o` are 0 and neither `load_o` nor `reinit_o` is asserted.
- R2: A write with `wr_addr` equal to 0 copies `wr_data[2:0]` into the hardware arm bits and `wr_data[3]` into the software bit. The bits appear on `trig_o` at the same positions from the next cycle. A write to any other address changes nothing.
- R3: A hardware trigger event is the rising edge of `hw_trig_i[n]` after a two-flop synchronizer. A line that stays high produces no further event.
- R4: An event on a line whose arm bit is 0 causes no load and leaves all trigger bits unchanged.
- R5: An accepted event on line n clears arm bit n only. The other arm bits keep their values.
- R6: If an accepted event on line n and a write setting arm bit n fall in the same cycle, the load still takes place and bit n stays 1.
- R7: Writing 1 to the software bit requests a load, and the bit clears in the cycle the load strobe appears. Writing 0 to the software bit withdraws a request that has not yet been served, and no load follows.
- R8: If a write setting the software bit coincides with the boundary that serves the pending software request, the load is made and the software bit stays 1.
- R9: With `reinit_mode_i` low, `load_o` rises only in the cycle after a cycle in which `boundary_i` was high and a request was pending. `reinit_o` stays low.
- R10: With `reinit_mode_i` high, `load_o` and `reinit_o` pulse together in the cycle after the request, regardless of `boundary_i`.
- R11: Any number of requests pending at the same boundary produce exactly one single-cycle `load_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| hw_trig_i | input | 3 | Asynchronous hardware trigger lines |
| boundary_i | input | 1 | Counter at minimum or maximum in this cycle |
| reinit_mode_i | input | 1 | 1: load immediately and reinitialize the counter; 0: wait for the boundary |
| load_o | output | 1 | One-cycle load strobe for period and compare registers |
| reinit_o | output | 1 | One-cycle counter reinitialization pulse |
| trig_o | output | 4 | Current trigger bits: [2:0] hardware arm bits, [3] software bit |

## Verification
The bench builds the block with its default parameters: three hardware lines, a two-stage synchronizer, an 8-bit data bus and a 2-bit address.

With three lines, the bench can raise two lines at once while the third stays armed. This shows that the clears are selective and that pending requests merge into one load.

The 2-bit address leaves three unused addresses, which are used to confirm that stray writes are ignored. The short synchronizer fixes the event latency at two cycles, so the same-cycle collisions of write and clear can be placed exactly.

// File: rtl/psync_pkg.sv
package psync_pkg;
  typedef enum logic {
    LOAD_AT_BOUNDARY = 1'b0,
    LOAD_IMMEDIATE   = 1'b1
  } load_mode_e;

  function automatic logic any_set(input logic [31:0] v);
    return |v;
  endfunction
endpackage

// File: rtl/psync_edge_detect.sv
module psync_edge_detect #(
  parameter int N_LINES = 3,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] evt_o
);
  localparam int TOP = STAGES - 1;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], line_i[g]};
        prev_q  <= chain_q[TOP];
      end
    end

    assign evt_o[g] = chain_q[TOP] & ~prev_q;

    // R3: an edge event lasts one cycle only
    assert_evt_single_R3: assert property (@(posedge clk) disable iff (rst)
      evt_o[g] |=> !evt_o[g]);
  end
endmodule

// File: rtl/psync_trig_regs.sv
module psync_trig_regs #(
  parameter int N_LINES   = 3,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [N_LINES-1:0] hw_hit_i,
  input  logic               sw_done_i,
  output logic [N_LINES-1:0] arm_o,
  output logic               sw_o
);
  localparam int SW_POS = N_LINES;

  logic wr_hit;
  assign wr_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_o <= '0;
      sw_o  <= 1'b0;
    end else if (wr_hit) begin
      arm_o <= wr_data[N_LINES-1:0];
      sw_o  <= wr_data[SW_POS];
    end else begin
      arm_o <= arm_o & ~hw_hit_i;
      sw_o  <= sw_o & ~sw_done_i;
    end
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_chk
    // R5: a consumed trigger disarms its own bit
    assert_hit_clears_R5: assert property (@(posedge clk) disable iff (rst)
      (hw_hit_i[g] && !wr_en) |=> !arm_o[g]);
    // R6: a set-write wins over the clear
    assert_write_wins_R6: assert property (@(posedge clk) disable iff (rst)
      (wr_hit && wr_data[g]) |=> arm_o[g]);
  end

  // R8: a set-write of the software bit wins over its completion
  assert_sw_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wr_data[SW_POS]) |=> sw_o);
  // R7: completion clears the software bit
  assert_sw_done_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (sw_done_i && !wr_en) |=> !sw_o);
endmodule

// File: rtl/psync_load_ctrl.sv
module psync_load_ctrl #(
  parameter int N_LINES = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] hw_hit_i,
  input  logic               sw_req_i,
  input  logic               boundary_i,
  input  logic               mode_i,
  output logic               sw_done_o,
  output logic               load_o,
  output logic               reinit_o
);
  import psync_pkg::*;

  logic pend_q;
  logic req;
  logic fire;
  load_mode_e mode;

  assign mode      = load_mode_e'(mode_i);
  assign req       = pend_q | (|hw_hit_i) | sw_req_i;
  assign fire      = req && ((mode == LOAD_IMMEDIATE) || boundary_i);
  assign sw_done_o = fire & sw_req_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      load_o   <= 1'b0;
      reinit_o <= 1'b0;
    end else begin
      pend_q   <= fire ? 1'b0 : (pend_q | (|hw_hit_i));
      load_o   <= fire;
      reinit_o <= fire && (mode == LOAD_IMMEDIATE);
    end
  end

  // R9: in boundary mode a load follows a boundary cycle
  assert_load_at_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    (load_o && !$past(mode_i)) |-> $past(boundary_i));
  // R10: a reinitialization pulse always comes with a load
  assert_reinit_with_load_R10: assert property (@(posedge clk) disable iff (rst)
    reinit_o |-> load_o);
  // R11: a boundary-mode load leaves nothing pending behind it
  assert_one_load_R11: assert property (@(posedge clk) disable iff (rst)
    (load_o && !reinit_o && !$past(mode_i)) |-> !pend_q);
endmodule

// File: rtl/psync_trigger_ctrl.sv
module psync_trigger_ctrl #(
  parameter int N_LINES   = 3,
  parameter int STAGES    = 2,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [N_LINES-1:0]   hw_trig_i,
  input  logic                 boundary_i,
  input  logic                 reinit_mode_i,
  output logic                 load_o,
  output logic                 reinit_o,
  output logic [N_LINES:0]     trig_o
);
  logic [N_LINES-1:0] evt;
  logic [N_LINES-1:0] arm;
  logic [N_LINES-1:0] hit;
  logic               sw_bit;
  logic               sw_done;

  psync_edge_detect #(.N_LINES(N_LINES), .STAGES(STAGES)) u_edge (
    .clk(clk), .rst(rst), .line_i(hw_trig_i), .evt_o(evt)
  );

  assign hit = evt & arm;

  psync_trig_regs #(
    .N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hw_hit_i(hit), .sw_done_i(sw_done), .arm_o(arm), .sw_o(sw_bit)
  );

  psync_load_ctrl #(.N_LINES(N_LINES)) u_load (
    .clk(clk), .rst(rst), .hw_hit_i(hit), .sw_req_i(sw_bit),
    .boundary_i(boundary_i), .mode_i(reinit_mode_i),
    .sw_done_o(sw_done), .load_o(load_o), .reinit_o(reinit_o)
  );

  assign trig_o = {sw_bit, arm};

  // R4: a disarmed line never disarms or sets anything
  assert_disarmed_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (evt != '0 && arm == '0 && !sw_bit && !wr_en) |=> (trig_o == '0));
endmodule

// File: tb/sim_psync_trigger_ctrl.sv
module sim_psync_trigger_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] hw = '0;
  logic       bnd = 1'b0;
  logic       mode = 1'b0;
  logic       load, reinit;
  logic [3:0] trig;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  psync_trigger_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hw_trig_i(hw), .boundary_i(bnd), .reinit_mode_i(mode),
    .load_o(load), .reinit_o(reinit), .trig_o(trig)
  );

  // {addr[1:0], data[7:0], expected trig[3:0]}
  localparam logic [13:0] VEC [6] = '{
    {2'd0, 8'h05, 4'h5},
    {2'd0, 8'h0A, 4'hA},
    {2'd1, 8'h0F, 4'hA},
    {2'd0, 8'h0F, 4'hF},
    {2'd3, 8'h00, 4'hF},
    {2'd0, 8'h00, 4'h0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  // raise lines, wait until the event is active in the current cycle
  task automatic raise(input logic [2:0] m);
    hw = hw | m;
    step();
    step();
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 1'b0;
    step();
    check("R1 trig", trig, 0);
    check("R1 load", {reinit, load}, 0);

    // R2 table walk: boundary mode, no boundary, so no load appears
    for (int i = 0; i < 6; i++) begin
      write(VEC[i][13:12], VEC[i][11:4]);
      check("R2 trig", trig, VEC[i][3:0]);
      check("R2 load", load, 0);
    end

    // R4: disarmed line, immediate mode
    mode = 1'b1;
    raise(3'b100);
    step();
    check("R4 load", load, 0);
    step();
    check("R4 trig", trig, 0);
    hw = '0; step(); step(); step();

    // R5/R10: arm all, line 1 fires in immediate mode
    write(2'd0, 8'h07);
    raise(3'b010);
    step();
    check("R10 load", load, 1);
    check("R10 reinit", reinit, 1);
    check("R5 trig", trig, 4'h5);
    step();
    check("R10 single", load, 0);

    // R3: line held high, re-armed, no new event
    write(2'd0, 8'h02);
    step(); step(); step();
    check("R3 held", load, 0);
    check("R3 armed", trig, 4'h2);
    hw = '0; step(); step(); step();
    raise(3'b010);
    step();
    check("R3 new edge", load, 1);
    check("R3 cleared", trig, 0);
    hw = '0; step(); step(); step();

    // R6: event and set-write in the same cycle
    write(2'd0, 8'h01);
    hw = 3'b001; step();
    step();
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h01;
    step();
    wr_en = 1'b0;
    check("R6 load", load, 1);
    check("R6 trig", trig, 4'h1);
    hw = '0; step(); step(); step();
    write(2'd0, 8'h00);

    // R7 immediate software request
    write(2'd0, 8'h08);
    step();
    check("R7 imm load", load, 1);
    check("R7 imm clear", trig, 0);

    // R9: boundary mode software request
    mode = 1'b0;
    step();
    write(2'd0, 8'h08);
    step(); step();
    check("R9 wait", load, 0);
    check("R9 held", trig, 4'h8);
    bnd = 1'b1;
    step();
    bnd = 1'b0;
    check("R9 load", load, 1);
    check("R9 noreinit", reinit, 0);
    check("R7 clear", trig, 0);
    step();
    check("R9 single", load, 0);

    // R7: write 0 withdraws
    write(2'd0, 8'h08);
    write(2'd0, 8'h00);
    bnd = 1'b1; step(); bnd = 1'b0;
    check("R7 withdraw", load, 0);

    // R8: set-write at the serving boundary
    write(2'd0, 8'h08);
    bnd = 1'b1;
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h08;
    step();
    wr_en = 1'b0; bnd = 1'b0;
    check("R8 load", load, 1);
    check("R8 trig", trig, 4'h8);
    step();
    check("R8 gap", load, 0);
    bnd = 1'b1; step(); bnd = 1'b0;
    check("R8 second", load, 1);
    check("R8 clear", trig, 0);

    // R11: several requests merge into one load
    write(2'd0, 8'h0F);
    raise(3'b011);
    step();
    check("R11 wait", load, 0);
    check("R11 trig", trig, 4'hC);
    step();
    bnd = 1'b1; step(); bnd = 1'b0;
    check("R11 load", load, 1);
    check("R11 trig2", trig, 4'h4);
    step();
    check("R11 single", load, 0);
    bnd = 1'b1; step(); bnd = 1'b0;
    check("R11 none", load, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule